// File: doc/BRIEF.md
# Qualified Delayed Load Strobe Generator

This block turns the rising edge of an end-of-conversion signal into a single-cycle load strobe. It runs entirely in the pixel clock domain, which is about 66 MHz (a period of roughly 15.15 ns). Neither input is ever used as a clock. Each input passes through a short synchronizer and a one-flop delay, and edges are found by comparing the delayed copy with the current synchronized level.

A rising edge of end-of-conversion arms a pending flag. The strobe fires only when all of these hold at once:
- the flag is pending;
- end-of-conversion is still high;
- line-valid is low;
- each input has been free of transitions for at least a settling interval of `HOLD` clocks.

Each input has its own holdoff counter. The counter restarts on a rising or a falling transition of that input, then counts up and saturates at `HOLD`. Firing clears the pending flag, so each arming produces exactly one strobe.

Top module: `lp_strobe_gen`

## Requirements
- R1: `load_o` is high for exactly one clock cycle each time it fires.
- R2: A rising edge of `eoc_i` arms a pending flag. Firing clears the flag, so one arming yields exactly one strobe.
- R3: With `lval_i` long quiet and low, `load_o` is first seen high after exactly `HOLD`+4 rising clock edges, counted from the first edge that samples `eoc_i` high. The count is made of `SYNC_STAGES`=2 synchronizer flops, 1 edge register, `HOLD` holdoff counts and 1 output register. The strobe never comes earlier than `HOLD` clocks after the latest synchronized `eoc_i` transition.
- R4: The strobe never fires earlier than `HOLD` clocks after the latest synchronized `lval_i` transition. In general, it is due `HOLD`+4 edges after the later of the two inputs' last changes.
- R5: Both rising and falling transitions of an input restart that input's holdoff counter.
- R6: At the decision cycle `eoc_i` must be high and `lval_i` must be low, both as synchronized levels. While either condition fails, no strobe is issued and the pending flag is held.
- R7: A synchronous active-high `rst` clears `load_o`, the pending flag, both holdoff counters and the synchronizer flops. If `eoc_i` is high when `rst` is released, it counts as a fresh rising edge.
- R8: A holdoff counter saturates at `HOLD` rather than wrapping. An input that stays quiet for an arbitrarily long time therefore keeps its side qualified.
- R9: A new `eoc_i` rising edge while the flag is already pending keeps the flag set and restarts the holdoff. Only one strobe results, timed from the latest edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| eoc_i | input | 1 | End-of-conversion, asynchronous to `clk` |
| lval_i | input | 1 | Line-valid, asynchronous to `clk` |
| load_o | output | 1 | Single-cycle load strobe |

## Verification
An input change applied just after a clock edge shows up on `load_o` exactly `HOLD`+4 edges later. If the other input changed later, the count runs from that change instead. Every change in the 0 to 30 cycle timeline extends the wait by its own offset.

The bench applies input events at known cycle indices and samples `load_o` one nanosecond after each edge. It records the index of the first high sample, the number of high samples, and any back-to-back highs. It compares these with `max(event offsets) + HOLD + 4`, computed arithmetically. For cases where no strobe is expected, the whole window is checked for silence.

// File: rtl/lp_pkg.sv
package lp_pkg;

    // Synchronized view of one asynchronous input.
    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } edge_info_t;

    function automatic logic any_edge(edge_info_t e);
        return e.rise | e.fall;
    endfunction

    // Width needed to hold values 0..max_val.
    function automatic int count_width(int max_val);
        return (max_val < 1) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/lp_sync_edge.sv
module lp_sync_edge
    import lp_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       async_i,
    output edge_info_t info_o
);

    logic [STAGES-1:0] chain;
    logic              delayed;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= async_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], async_i};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) delayed <= 1'b0;
        else     delayed <= chain[STAGES-1];
    end

    always_comb begin
        info_o.level = chain[STAGES-1];
        info_o.rise  = chain[STAGES-1] & ~delayed;
        info_o.fall  = ~chain[STAGES-1] & delayed;
    end

endmodule

// File: rtl/lp_holdoff.sv
module lp_holdoff
    import lp_pkg::*;
#(
    parameter int HOLD = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  edge_info_t info_i,
    output logic       ready_o
);

    localparam int CW = count_width(HOLD);
    localparam logic [CW-1:0] LIMIT = CW'(HOLD);

    logic [CW-1:0] count;
    logic          restart;

    assign restart = any_edge(info_i);

    always_ff @(posedge clk) begin
        if (rst || restart)      count <= '0;
        else if (count != LIMIT) count <= count + 1'b1;
    end

    // An edge in the current cycle disqualifies even a saturated count.
    assign ready_o = (count == LIMIT) && !restart;

endmodule

// File: rtl/lp_arm.sv
module lp_arm (
    input  logic clk,
    input  logic rst,
    input  logic arm_i,
    input  logic qualify_i,
    output logic pulse_o,
    output logic pending_o
);

    logic fire;

    assign fire = pending_o & qualify_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending_o <= 1'b0;
            pulse_o   <= 1'b0;
        end else begin
            pulse_o <= fire;
            if (arm_i)     pending_o <= 1'b1;
            else if (fire) pending_o <= 1'b0;
        end
    end

endmodule

// File: rtl/lp_strobe_gen.sv
module lp_strobe_gen
    import lp_pkg::*;
#(
    parameter int HOLD        = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic eoc_i,
    input  logic lval_i,
    output logic load_o
);

    edge_info_t eoc_info;
    edge_info_t lval_info;
    logic       eoc_ready;
    logic       lval_ready;
    logic       qualify;
    logic       pending;
    logic       eoc_lvl;
    logic       lval_lvl;

    lp_sync_edge #(.STAGES(SYNC_STAGES)) u_sync_eoc (
        .clk    (clk),
        .rst    (rst),
        .async_i(eoc_i),
        .info_o (eoc_info)
    );

    lp_sync_edge #(.STAGES(SYNC_STAGES)) u_sync_lval (
        .clk    (clk),
        .rst    (rst),
        .async_i(lval_i),
        .info_o (lval_info)
    );

    lp_holdoff #(.HOLD(HOLD)) u_hold_eoc (
        .clk    (clk),
        .rst    (rst),
        .info_i (eoc_info),
        .ready_o(eoc_ready)
    );

    lp_holdoff #(.HOLD(HOLD)) u_hold_lval (
        .clk    (clk),
        .rst    (rst),
        .info_i (lval_info),
        .ready_o(lval_ready)
    );

    assign eoc_lvl  = eoc_info.level;
    assign lval_lvl = lval_info.level;
    assign qualify  = eoc_lvl & ~lval_lvl & eoc_ready & lval_ready;

    lp_arm u_arm (
        .clk      (clk),
        .rst      (rst),
        .arm_i    (eoc_info.rise),
        .qualify_i(qualify),
        .pulse_o  (load_o),
        .pending_o(pending)
    );

endmodule

// File: rtl/lp_strobe_chk.sv
module lp_strobe_chk #(
    parameter int HOLD = 4
) (
    input logic clk,
    input logic rst,
    input logic load_o,
    input logic pending,
    input logic eoc_lvl,
    input logic lval_lvl
);

    localparam int QW = $clog2(HOLD + 2) + 1;
    localparam logic [QW-1:0] QMAX = QW'(HOLD + 1);

    logic [QW-1:0] quiet_e;
    logic [QW-1:0] quiet_l;
    logic          eoc_q;
    logic          lval_q;

    // Independent count of cycles since each synchronized level last changed.
    always_ff @(posedge clk) begin
        if (rst) begin
            quiet_e <= '0;
            quiet_l <= '0;
            eoc_q   <= 1'b0;
            lval_q  <= 1'b0;
        end else begin
            eoc_q  <= eoc_lvl;
            lval_q <= lval_lvl;
            if (eoc_lvl != eoc_q)  quiet_e <= '0;
            else if (quiet_e != QMAX) quiet_e <= quiet_e + 1'b1;
            if (lval_lvl != lval_q) quiet_l <= '0;
            else if (quiet_l != QMAX) quiet_l <= quiet_l + 1'b1;
        end
    end

    assert_single_cycle_R1: assert property (@(posedge clk) disable iff (rst)
        load_o |=> !load_o);

    assert_fire_clears_R2: assert property (@(posedge clk) disable iff (rst)
        load_o |-> !pending);

    assert_eoc_holdoff_R3: assert property (@(posedge clk) disable iff (rst)
        load_o |-> (quiet_e >= QMAX));

    assert_lval_holdoff_R4: assert property (@(posedge clk) disable iff (rst)
        load_o |-> (quiet_l >= QMAX));

    assert_levels_qualify_R6: assert property (@(posedge clk) disable iff (rst)
        load_o |-> ($past(eoc_lvl) && !$past(lval_lvl)));

    assert_reset_clears_R7: assert property (@(posedge clk)
        rst |=> (!load_o && !pending));

endmodule

bind lp_strobe_gen lp_strobe_chk #(.HOLD(HOLD)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .load_o  (load_o),
    .pending (pending),
    .eoc_lvl (eoc_lvl),
    .lval_lvl(lval_lvl)
);

// File: tb/sim_lp_strobe_gen.sv
`timescale 1ns/1ps
module sim_lp_strobe_gen;

    localparam real CLK_PERIOD = 15.152;
    localparam int  HOLD       = 4;
    localparam int  LAT        = HOLD + 4;
    localparam int  NONE       = -1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic eoc = 1'b0;
    logic lval = 1'b1;
    logic load;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2.0) clk = ~clk;

    lp_strobe_gen #(.HOLD(HOLD), .SYNC_STAGES(2)) u0 (
        .clk   (clk),
        .rst   (rst),
        .eoc_i (eoc),
        .lval_i(lval),
        .load_o(load)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst  = 1'b1;
        eoc  = 1'b0;
        lval = 1'b1;
        repeat (3) step();
        rst = 1'b0;
        repeat (12) step();
    endtask

    // Apply events at cycle indices, then observe load for len cycles.
    task automatic run_win(input int e_on, input int e_off, input int e_on2,
                           input int l_off, input int l_on, input int l_off2,
                           input int len,
                           output int cnt, output int first, output int wide);
        bit prev = 1'b0;
        cnt = 0; first = -1; wide = 0;
        for (int t = 0; t < len; t++) begin
            if (t == e_on || t == e_on2) eoc = 1'b1;
            if (t == e_off)              eoc = 1'b0;
            if (t == l_off || t == l_off2) lval = 1'b0;
            if (t == l_on)               lval = 1'b1;
            step();
            if (load) begin
                cnt++;
                if (first < 0) first = t + 1;
                if (prev) wide++;
            end
            prev = load;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000.0);
        if (!finished) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int cnt, first, wide, exp_t;

        // R7: reset state
        repeat (3) step();
        chk(load == 1'b0, "R7 reset output", int'(load), 0);
        rst = 1'b0;

        // R3/R4/R1/R2: sweep eoc rise time and lval fall time
        for (int e = 0; e <= 6; e++) begin
            for (int l = 0; l <= 6; l++) begin
                do_reset();
                run_win(e, NONE, NONE, l, NONE, NONE, 30, cnt, first, wide);
                exp_t = ((e > l) ? e : l) + LAT;
                chk(first == exp_t, (e >= l) ? "R3 strobe timing" : "R4 strobe timing", first, exp_t);
                chk(cnt == 1, "R2 one strobe per arming", cnt, 1);
                chk(wide == 0, "R1 single cycle width", wide, 0);
            end
        end

        // R6: eoc drops before the decision cycle -> no strobe
        for (int a = 1; a <= 5; a++) begin
            do_reset();
            run_win(0, a, NONE, 0, NONE, NONE, 30, cnt, first, wide);
            chk(cnt == 0, "R6 eoc low blocks strobe", cnt, 0);
        end

        // R5/R9: re-arm while pending; fall and rise both restart holdoff
        for (int a = 1; a <= 3; a++) begin
            for (int b = a + 1; b <= a + 3; b++) begin
                do_reset();
                run_win(0, a, b, 0, NONE, NONE, 30, cnt, first, wide);
                chk(first == b + LAT, "R9 re-arm timing", first, b + LAT);
                chk(cnt == 1, "R9 single strobe after re-arm", cnt, 1);
            end
        end

        // R6/R5: lval high holds pending; lval falling later releases it
        do_reset();
        run_win(0, NONE, NONE, 0, 2, 20, 40, cnt, first, wide);
        chk(first == 20 + LAT, "R5 lval transitions restart holdoff", first, 20 + LAT);
        chk(cnt == 1, "R6 pending held while lval high", cnt, 1);

        // R6: lval stays high -> silent window
        do_reset();
        run_win(0, NONE, NONE, NONE, NONE, NONE, 40, cnt, first, wide);
        chk(cnt == 0, "R6 lval high blocks strobe", cnt, 0);

        // R7: reset while eoc held high; release counts as a new rise
        do_reset();
        run_win(0, NONE, NONE, 0, NONE, NONE, 4, cnt, first, wide);
        rst = 1'b1;
        for (int k = 0; k < 10; k++) begin
            step();
            chk(load == 1'b0, "R7 load low during reset", int'(load), 0);
        end
        rst = 1'b0;
        run_win(NONE, NONE, NONE, NONE, NONE, NONE, 30, cnt, first, wide);
        chk(first == LAT, "R7 timing after reset release", first, LAT);
        chk(cnt == 1, "R7 one strobe after reset", cnt, 1);

        // R8: long quiet on lval, then eoc rises much later
        do_reset();
        run_win(300, NONE, NONE, 0, NONE, NONE, 330, cnt, first, wide);
        chk(first == 300 + LAT, "R8 saturated holdoff keeps qualification", first, 300 + LAT);
        chk(cnt == 1, "R8 single strobe", cnt, 1);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule